// File: doc/BRIEF.md
# Trap Auxiliary Value Register Writer

This block holds the first and second trap-value registers of a capability-checking RISC-V hart, one pair for each trap destination: machine mode, supervisor mode (HS or S) and virtual supervisor mode (VS). When the trap logic takes an exception, it pulses a strobe. With the strobe it supplies the destination mode, the exception class, the capability fault type and cause codes, and the faulting address. The block then writes the address into the selected first register and an auxiliary code into the selected second register.

The auxiliary code depends on the exception class. For a capability fault it packs the fault type and cause. For a load or store/AMO page fault it gives a small code that tells apart a plain page fault, a capability page-table fault, and both faults at once. Every other exception clears the register.

Software reaches all six registers through a simple CSR port. Reads are registered. A mode may be built so that its first register reads zero for capability faults. In that case its second register is also zero for those faults.

Top module: `trap_aux_csr`

## Requirements
- R1: After reset, all six registers read back zero.
- R2: A trap with destination mode 0 (M), 1 (HS/S) or 2 (VS) writes the faulting address into that mode's first register at CSR address 0x343, 0x143 or 0x243 respectively.
- R3: A trap of class 1 (capability fault) writes the second register as the type code (0 fetch, 1 data, 2 jump/branch) in bits [19:16] and the cause code in bits [3:0], with every other bit zero.
- R4: Page-fault classes write the second register as follows: class 2 (plain page fault) writes 0, class 3 (capability page-table fault) writes 1, and class 4 (both faults detected together) writes 2.
- R5: A trap of class 0 (any other exception) writes the second register of its mode to zero, overwriting any earlier value.
- R6: Only the destination mode's pair changes on a trap. A destination code of 3 changes no register.
- R7: CSR writes to 0x343/0x34b, 0x143/0x14b and 0x243/0x24b set the addressed register. A read returns the addressed register on the cycle after the address is presented. An unmapped address reads zero, and writes to it change nothing.
- R8: When a trap and a CSR write to the same register occur in one cycle, the trap value is kept.
- R9: For a mode whose bit is set in RO_ZERO_MASK, a capability fault (class 1) into that mode writes zero into both of its registers. The other classes behave as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | One-cycle exception strobe |
| trap_mode | input | 2 | Destination mode: 0 M, 1 HS/S, 2 VS, 3 none |
| trap_class | input | 3 | Exception class, 0 to 4 |
| trap_ftype | input | 4 | Capability fault type code |
| trap_fcause | input | 4 | Capability fault cause code |
| trap_addr | input | XLEN | Faulting address |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | CSR write enable |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | Registered CSR read data |

## Verification
The hardest case to reach from the ports is a trap and a software write that hit the same register in the same cycle. The bench drives the strobe and the write enable on one clock with different data, then reads the register back. A second instance with a read-only-zero mask shows that the masked mode zeroes both registers on a capability fault. The same instance shows that the unmasked modes are unaffected. The vector table puts class 0 traps after nonzero writes to the same mode. This shows that the register is actively cleared rather than merely left alone.

// File: rtl/trap_aux_pkg.sv
package trap_aux_pkg;

  localparam int NUM_MODES = 3;

  typedef enum logic [1:0] {
    MODE_M  = 2'd0,
    MODE_S  = 2'd1,
    MODE_VS = 2'd2,
    MODE_NONE = 2'd3
  } trap_mode_e;

  typedef enum logic [2:0] {
    EXC_OTHER    = 3'd0,
    EXC_CAP      = 3'd1,
    EXC_PG_PLAIN = 3'd2,
    EXC_PG_CAP   = 3'd3,
    EXC_PG_BOTH  = 3'd4
  } exc_class_e;

  localparam logic [11:0] ADDR_TVAL  [NUM_MODES] = '{12'h343, 12'h143, 12'h243};
  localparam logic [11:0] ADDR_TVAL2 [NUM_MODES] = '{12'h34b, 12'h14b, 12'h24b};

  localparam int TYPE_LSB  = 16;
  localparam int FIELD_W   = 4;

endpackage

// File: rtl/trap_aux_encode.sv
module trap_aux_encode
  import trap_aux_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [2:0]        cls,
  input  logic [FIELD_W-1:0] ftype,
  input  logic [FIELD_W-1:0] fcause,
  input  logic [XLEN-1:0]   addr,
  input  logic              ro_zero,
  output logic [XLEN-1:0]   tval,
  output logic [XLEN-1:0]   tval2
);

  exc_class_e cls_e;
  assign cls_e = exc_class_e'(cls);

  always_comb begin
    tval  = addr;
    tval2 = '0;
    unique case (cls_e)
      EXC_CAP: begin
        if (ro_zero) begin
          tval = '0;
        end else begin
          tval2[TYPE_LSB +: FIELD_W] = ftype;
          tval2[FIELD_W-1:0]         = fcause;
        end
      end
      EXC_PG_CAP:  tval2 = XLEN'(1);
      EXC_PG_BOTH: tval2 = XLEN'(2);
      default:     tval2 = '0;
    endcase
  end

endmodule

// File: rtl/trap_aux_bank.sv
module trap_aux_bank
  import trap_aux_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit RO_ZERO = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_hit,
  input  logic [2:0]      trap_cls,
  input  logic [XLEN-1:0] new_tval,
  input  logic [XLEN-1:0] new_tval2,
  input  logic            wr_tval,
  input  logic            wr_tval2,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] tval_q,
  output logic [XLEN-1:0] tval2_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tval_q  <= '0;
      tval2_q <= '0;
    end else if (trap_hit) begin
      tval_q  <= new_tval;
      tval2_q <= new_tval2;
    end else begin
      if (wr_tval)  tval_q  <= wdata;
      if (wr_tval2) tval2_q <= wdata;
    end
  end

  AST_TRAP_WINS: assert property (@(posedge clk) disable iff (rst)
    trap_hit |=> (tval_q == $past(new_tval)) && (tval2_q == $past(new_tval2))); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!trap_hit && !wr_tval && !wr_tval2) |=> $stable(tval_q) && $stable(tval2_q)); // R6

  AST_RO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (RO_ZERO && trap_hit && trap_cls == EXC_CAP) |=> (tval_q == '0) && (tval2_q == '0)); // R9

endmodule

// File: rtl/trap_aux_csr.sv
module trap_aux_csr
  import trap_aux_pkg::*;
#(
  parameter int                   XLEN         = 64,
  parameter logic [NUM_MODES-1:0] RO_ZERO_MASK = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_valid,
  input  logic [1:0]      trap_mode,
  input  logic [2:0]      trap_class,
  input  logic [3:0]      trap_ftype,
  input  logic [3:0]      trap_fcause,
  input  logic [XLEN-1:0] trap_addr,
  input  logic [11:0]     csr_addr,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata
);

  logic [XLEN-1:0] tval_q  [NUM_MODES];
  logic [XLEN-1:0] tval2_q [NUM_MODES];
  logic [XLEN-1:0] rd_mux;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_MODES; gi++) begin : g_mode
      logic            hit;
      logic            wr1;
      logic            wr2;
      logic [XLEN-1:0] enc_tval;
      logic [XLEN-1:0] enc_tval2;

      assign hit = trap_valid && (trap_mode == gi[1:0]);
      assign wr1 = csr_we && (csr_addr == ADDR_TVAL[gi]);
      assign wr2 = csr_we && (csr_addr == ADDR_TVAL2[gi]);

      trap_aux_encode #(.XLEN(XLEN)) u_enc (
        .cls     (trap_class),
        .ftype   (trap_ftype),
        .fcause  (trap_fcause),
        .addr    (trap_addr),
        .ro_zero (RO_ZERO_MASK[gi]),
        .tval    (enc_tval),
        .tval2   (enc_tval2)
      );

      trap_aux_bank #(.XLEN(XLEN), .RO_ZERO(RO_ZERO_MASK[gi])) u_bank (
        .clk       (clk),
        .rst       (rst),
        .trap_hit  (hit),
        .trap_cls  (trap_class),
        .new_tval  (enc_tval),
        .new_tval2 (enc_tval2),
        .wr_tval   (wr1),
        .wr_tval2  (wr2),
        .wdata     (csr_wdata),
        .tval_q    (tval_q[gi]),
        .tval2_q   (tval2_q[gi])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int m = 0; m < NUM_MODES; m++) begin
      if (csr_addr == ADDR_TVAL[m])  rd_mux = tval_q[m];
      if (csr_addr == ADDR_TVAL2[m]) rd_mux = tval2_q[m];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) csr_rdata <= '0;
    else     csr_rdata <= rd_mux;
  end

  AST_OTHER_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && trap_mode == MODE_M && trap_class == EXC_OTHER) |=> tval2_q[0] == '0); // R5

  AST_PAGE_CODE: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && trap_mode == MODE_S && trap_class == EXC_PG_BOTH) |=> tval2_q[1] == XLEN'(2)); // R4

  AST_NONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && trap_mode == MODE_NONE && !csr_we)
      |=> $stable(tval_q[0]) && $stable(tval2_q[0]) && $stable(tval_q[1])
          && $stable(tval2_q[1]) && $stable(tval_q[2]) && $stable(tval2_q[2])); // R6

  AST_CAP_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && trap_mode == MODE_VS && trap_class == EXC_CAP && !RO_ZERO_MASK[2])
      |=> tval2_q[2] == ((XLEN'($past(trap_ftype)) << TYPE_LSB) | XLEN'($past(trap_fcause)))); // R3

endmodule

// File: tb/tb_trap_aux_csr.sv
module tb_trap_aux_csr;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst;
  logic            trap_valid;
  logic [1:0]      trap_mode;
  logic [2:0]      trap_class;
  logic [3:0]      trap_ftype;
  logic [3:0]      trap_fcause;
  logic [XLEN-1:0] trap_addr;
  logic [11:0]     csr_addr;
  logic            csr_we;
  logic [XLEN-1:0] csr_wdata;
  logic [XLEN-1:0] csr_rdata;
  logic [XLEN-1:0] ro_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  trap_aux_csr #(.XLEN(XLEN)) dut (
    .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_mode(trap_mode),
    .trap_class(trap_class), .trap_ftype(trap_ftype), .trap_fcause(trap_fcause),
    .trap_addr(trap_addr), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
  );

  trap_aux_csr #(.XLEN(XLEN), .RO_ZERO_MASK(3'b010)) dut_ro (
    .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_mode(trap_mode),
    .trap_class(trap_class), .trap_ftype(trap_ftype), .trap_fcause(trap_fcause),
    .trap_addr(trap_addr), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(ro_rdata)
  );

  localparam logic [11:0] A1 [3] = '{12'h343, 12'h143, 12'h243};
  localparam logic [11:0] A2 [3] = '{12'h34b, 12'h14b, 12'h24b};

  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  cls;
    logic [3:0]  ftype;
    logic [3:0]  fcause;
    logic [63:0] addr;
    logic [63:0] exp2;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd1, 4'd1, 4'd2, 64'h0000_0000_0000_1000, 64'h0000_0000_0001_0002}, // R3 data
    '{2'd2, 3'd1, 4'd2, 4'hf, 64'h8000_0000_dead_0000, 64'h0000_0000_0002_000f}, // R3 jump
    '{2'd1, 3'd1, 4'd0, 4'h7, 64'h0000_0000_0000_2222, 64'h0000_0000_0000_0007}, // R3 fetch
    '{2'd1, 3'd4, 4'd3, 4'h3, 64'h0000_0000_0000_3000, 64'h0000_0000_0000_0002}, // R4 both
    '{2'd0, 3'd3, 4'd1, 4'h1, 64'h0000_0000_0000_4000, 64'h0000_0000_0000_0001}, // R4 cap pte
    '{2'd2, 3'd2, 4'd1, 4'h1, 64'h0000_0000_0000_5000, 64'h0000_0000_0000_0000}, // R4 plain
    '{2'd0, 3'd0, 4'd2, 4'h9, 64'h0000_0000_0000_6000, 64'h0000_0000_0000_0000}, // R5 clears M
    '{2'd1, 3'd0, 4'd1, 4'h5, 64'hffff_ffff_ffff_fff0, 64'h0000_0000_0000_0000}, // R5 clears S
    '{2'd3, 3'd1, 4'd1, 4'h4, 64'h0000_0000_0000_7777, 64'h0000_0000_0000_0000}, // R6 no target
    '{2'd2, 3'd3, 4'd0, 4'h0, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_0001}  // R4 VS
  };

  logic [XLEN-1:0] m_tval  [3];
  logic [XLEN-1:0] m_tval2 [3];

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [XLEN-1:0] v, output logic [XLEN-1:0] vro);
    csr_addr = a;
    csr_we   = 1'b0;
    @(posedge clk);
    @(negedge clk);
    v   = csr_rdata;
    vro = ro_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] d);
    csr_addr  = a;
    csr_wdata = d;
    csr_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic trap(input logic [1:0] m, input logic [2:0] c, input logic [3:0] t,
                      input logic [3:0] k, input logic [XLEN-1:0] a);
    trap_valid  = 1'b1;
    trap_mode   = m;
    trap_class  = c;
    trap_ftype  = t;
    trap_fcause = k;
    trap_addr   = a;
    @(posedge clk);
    @(negedge clk);
    trap_valid = 1'b0;
  endtask

  task automatic check_all(input string req);
    logic [XLEN-1:0] v, vro;
    for (int m = 0; m < 3; m++) begin
      rd(A1[m], v, vro);
      check(req, v, m_tval[m]);
      rd(A2[m], v, vro);
      check(req, v, m_tval2[m]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] v, vro;
    rst = 1'b1; trap_valid = 1'b0; trap_mode = '0; trap_class = '0;
    trap_ftype = '0; trap_fcause = '0; trap_addr = '0;
    csr_addr = '0; csr_we = 1'b0; csr_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    for (int m = 0; m < 3; m++) begin m_tval[m] = '0; m_tval2[m] = '0; end
    check_all("R1 reset");

    // R7: software writes then read back; preload nonzero so R5 clears are visible
    for (int m = 0; m < 3; m++) begin
      wr(A1[m], 64'h1111_0000_0000_0000 + XLEN'(m));
      wr(A2[m], 64'h2222_0000_0000_0000 + XLEN'(m));
      m_tval[m]  = 64'h1111_0000_0000_0000 + XLEN'(m);
      m_tval2[m] = 64'h2222_0000_0000_0000 + XLEN'(m);
    end
    check_all("R7 csr write");

    // R7: unmapped address reads zero and a write there changes nothing
    wr(12'h34c, 64'hffff);
    rd(12'h34c, v, vro);
    check("R7 unmapped read", v, '0);
    check_all("R7 unmapped write");

    // R2..R6: vector table
    for (int i = 0; i < NV; i++) begin
      trap(VECS[i].mode, VECS[i].cls, VECS[i].ftype, VECS[i].fcause, VECS[i].addr);
      if (VECS[i].mode != 2'd3) begin
        m_tval[VECS[i].mode]  = VECS[i].addr;
        m_tval2[VECS[i].mode] = VECS[i].exp2;
      end
      check_all("R2-vector");
    end

    // R8: trap and CSR write to the same register in one cycle
    csr_addr  = A2[0];
    csr_wdata = 64'habcd;
    csr_we    = 1'b1;
    trap(2'd0, 3'd4, 4'd0, 4'd0, 64'h9000);
    csr_we = 1'b0;
    m_tval[0] = 64'h9000; m_tval2[0] = 64'd2;
    check_all("R8 trap beats write");

    // R9: masked S mode on dut_ro zeroes both on capability fault
    trap(2'd1, 3'd1, 4'd1, 4'd3, 64'hcafe);
    m_tval[1] = 64'hcafe; m_tval2[1] = 64'h0001_0003;
    check_all("R9 unmasked dut");
    rd(A1[1], v, vro);
    check("R9 ro tval", vro, '0);
    rd(A2[1], v, vro);
    check("R9 ro tval2", vro, '0);
    // R9: other classes into masked mode behave as usual
    trap(2'd1, 3'd3, 4'd0, 4'd0, 64'hbeef);
    rd(A1[1], v, vro);
    check("R9 ro page tval", vro, 64'hbeef);
    rd(A2[1], v, vro);
    check("R9 ro page tval2", vro, 64'd1);
    // R9: unmasked mode M on dut_ro keeps fields
    trap(2'd0, 3'd1, 4'd2, 4'd6, 64'h4242);
    rd(A2[0], v, vro);
    check("R9 ro unmasked M", vro, 64'h0002_0006);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule